// File: doc/BRIEF.md
# Chained Bit-Slice Pattern Matcher

This block watches a set of asynchronous input pins and raises match indications when a boolean expression over them becomes true. The expression is a sum of products built from a chain of identical slices. Each slice picks one pin and tests one condition on it: a level, an edge, or an edge that is remembered until it is cleared. Neighbouring slices are ANDed together. A slice flagged as an endpoint closes the running product and reports it on its own bit of the match vector. The ORed result of all products can also drive a single event line.

Configuration is written one slice at a time through a small write port that carries the slice index, source, condition and endpoint flag. A mode input lets the per-slice interrupt lines carry the match results instead of the plain pin-interrupt requests. A clear strobe erases every remembered edge and also records which slices were matching in that cycle.

Top module: `pmatch_engine`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, match_status, event_out and detect_snapshot are all zero, and every slice holds condition code 6 (never), source 0 and a clear endpoint flag.
- R2: A slice evaluates the input pin whose index equals its 3-bit source field; a change on any other pin has no effect on that slice.
- R3: Condition code 0 is always true, code 6 is never true, code 4 is true while the selected pin is high and code 5 while it is low.
- R4: Codes 1 (rise), 2 (fall) and 3 (either edge) are true from the cycle the edge is seen and stay true until clear_sticky is pulsed or that slice is rewritten through the write port.
- R5: Code 7 is true only in the single cycle in which a rising or falling edge of the selected pin is seen.
- R6: Slice k with its endpoint flag set drives match_status[k] with the AND of the conditions of slices j+1..k, where j is the previous endpoint (or -1); bits of slices that are not endpoints are zero.
- R7: The last slice closes a product term whatever the value of its endpoint flag.
- R8: irq_out equals match_status while pm_enable is high and equals plain_irq while it is low.
- R9: event_out is high in the cycle after any product term matched while both event_enable and pm_enable were high, and low otherwise.
- R10: A pulse on clear_sticky loads detect_snapshot with the product-term results of that cycle; detect_snapshot holds otherwise.
- R11: A level change on a pin reaches match_status after the third rising clock edge (two synchroniser stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_INPUTS | Asynchronous input pins |
| cfg_we | input | 1 | Write strobe for one slice's configuration |
| cfg_sel | input | $clog2(NUM_SLICES) | Index of the slice being written |
| cfg_src | input | $clog2(NUM_INPUTS) | Pin index for the slice |
| cfg_mode | input | 3 | Condition code 0..7 |
| cfg_endpoint | input | 1 | Endpoint flag for the slice |
| pm_enable | input | 1 | Route match results to irq_out and allow the event line |
| event_enable | input | 1 | Enable the combined event output |
| clear_sticky | input | 1 | Clear all remembered edges and capture a snapshot |
| plain_irq | input | NUM_SLICES | Plain pin-interrupt requests used when pm_enable is low |
| match_status | output | NUM_SLICES | Registered product-term results, one bit per endpoint slice |
| irq_out | output | NUM_SLICES | Interrupt lines, match results or plain requests |
| event_out | output | 1 | Registered OR of all product terms |
| detect_snapshot | output | NUM_SLICES | Product-term results captured at the last clear |

## Verification
The properties assume the write port is used for at most one slice per cycle with an in-range index, and that clear_sticky and cfg_we are sampled as single-cycle synchronous strobes; the bench drives all control inputs one nanosecond after the rising edge so they are stable at every sampling edge. The pins are treated as asynchronous by the block but the bench changes them only between edges, so the two-stage synchroniser has a deterministic delay that the reference model reproduces. Random configuration writes always use legal slice indices and any of the eight condition codes, which keeps the stimulus inside what the assertions take for granted.

// File: rtl/pmatch_pkg.sv
// Package: shared condition encoding for the pattern matcher.
// Assumes the condition field is exactly three bits wide.
package pmatch_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_ALWAYS   = 3'd0,
        PM_STK_RISE = 3'd1,
        PM_STK_FALL = 3'd2,
        PM_STK_ANY  = 3'd3,
        PM_HIGH     = 3'd4,
        PM_LOW      = 3'd5,
        PM_NEVER    = 3'd6,
        PM_EDGE     = 3'd7
    } pm_mode_e;
endpackage

// File: rtl/pmatch_sync.sv
// Module: two-flop synchroniser for the pin bus plus one extra stage
// holding the previous synchronised sample for edge detection.
// Assumes pins may change at any time relative to clk.
module pmatch_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync_q,
    output logic [WIDTH-1:0] prev_q
);
    logic [WIDTH-1:0] meta_q;

    // Purpose: resolve metastability, then keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/pmatch_slice.sv
// Module: one bit slice. Selects a pin, evaluates the configured
// condition and keeps a remembered-edge flag for the sticky codes.
// Assumes lvl/prv are synchronous samples one cycle apart.
module pmatch_slice
    import pmatch_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    localparam int SRC_W = $clog2(NUM_INPUTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_INPUTS-1:0] lvl,
    input  logic [NUM_INPUTS-1:0] prv,
    input  logic [SRC_W-1:0]      src,
    input  pm_mode_e              mode,
    input  logic                  clr,
    output logic                  term,
    output logic                  sticky_q
);
    logic bit_now;
    logic bit_old;
    logic rise;
    logic fall;
    logic edge_hit;

    // Purpose: pick the source pin and derive its edges.
    always_comb begin
        bit_now = lvl[src];
        bit_old = prv[src];
        rise    = bit_now & ~bit_old;
        fall    = ~bit_now & bit_old;
    end

    // Purpose: edge that arms the remembered flag for the current code.
    always_comb begin
        unique case (mode)
            PM_STK_RISE: edge_hit = rise;
            PM_STK_FALL: edge_hit = fall;
            PM_STK_ANY:  edge_hit = rise | fall;
            default:     edge_hit = 1'b0;
        endcase
    end

    // Purpose: condition result of this slice for the current cycle.
    always_comb begin
        unique case (mode)
            PM_ALWAYS:   term = 1'b1;
            PM_STK_RISE,
            PM_STK_FALL,
            PM_STK_ANY:  term = sticky_q | edge_hit;
            PM_HIGH:     term = bit_now;
            PM_LOW:      term = ~bit_now;
            PM_NEVER:    term = 1'b0;
            PM_EDGE:     term = rise | fall;
            default:     term = 1'b0;
        endcase
    end

    // Purpose: remember an edge until clear or reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (clr) begin
            sticky_q <= 1'b0;
        end else if (edge_hit) begin
            sticky_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pmatch_chain.sv
// Module: folds slice conditions into product terms split at endpoints.
// Assumes ep_mask already has its top bit forced to one.
module pmatch_chain #(
    parameter int NUM_SLICES = 8
) (
    input  logic [NUM_SLICES-1:0] term,
    input  logic [NUM_SLICES-1:0] ep_mask,
    output logic [NUM_SLICES-1:0] prod
);
    logic run;

    // Purpose: running AND, emitted and restarted at every endpoint.
    always_comb begin
        run  = 1'b1;
        prod = '0;
        for (int k = 0; k < NUM_SLICES; k++) begin
            run = run & term[k];
            if (ep_mask[k]) begin
                prod[k] = run;
                run     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmatch_engine.sv
// Module: top of the pattern matcher. Holds per-slice configuration,
// instantiates the synchroniser, the slices and the product chain,
// and registers the match, event and snapshot outputs.
// Assumes cfg_sel is below NUM_SLICES when cfg_we is high.
module pmatch_engine
    import pmatch_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    parameter int NUM_INPUTS = 8,
    localparam int IDX_W = $clog2(NUM_SLICES),
    localparam int SRC_W = $clog2(NUM_INPUTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_INPUTS-1:0] pin_in,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_sel,
    input  logic [SRC_W-1:0]      cfg_src,
    input  logic [MODE_W-1:0]     cfg_mode,
    input  logic                  cfg_endpoint,
    input  logic                  pm_enable,
    input  logic                  event_enable,
    input  logic                  clear_sticky,
    input  logic [NUM_SLICES-1:0] plain_irq,
    output logic [NUM_SLICES-1:0] match_status,
    output logic [NUM_SLICES-1:0] irq_out,
    output logic                  event_out,
    output logic [NUM_SLICES-1:0] detect_snapshot
);
    logic [SRC_W-1:0]      src_q  [NUM_SLICES];
    pm_mode_e              mode_q [NUM_SLICES];
    logic [NUM_SLICES-1:0] ep_q;
    logic [NUM_SLICES-1:0] ep_mask;
    logic [NUM_INPUTS-1:0] pin_sync;
    logic [NUM_INPUTS-1:0] pin_prev;
    logic [NUM_SLICES-1:0] term_vec;
    logic [NUM_SLICES-1:0] sticky_vec;
    logic [NUM_SLICES-1:0] prod;
    logic [NUM_SLICES-1:0] match_q;
    logic [NUM_SLICES-1:0] snap_q;
    logic                  event_q;

    // Purpose: per-slice configuration storage, one slice per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SLICES; k++) begin
                src_q[k]  <= '0;
                mode_q[k] <= PM_NEVER;
            end
            ep_q <= '0;
        end else if (cfg_we) begin
            src_q[cfg_sel]  <= cfg_src;
            mode_q[cfg_sel] <= pm_mode_e'(cfg_mode);
            ep_q[cfg_sel]   <= cfg_endpoint;
        end
    end

    pmatch_sync #(
        .WIDTH (NUM_INPUTS)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .sync_q (pin_sync),
        .prev_q (pin_prev)
    );

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        logic clr_k;

        // Purpose: clear this slice's flag on global clear or rewrite.
        always_comb clr_k = clear_sticky | (cfg_we && (cfg_sel == IDX_W'(k)));

        // Purpose: the last slice always closes a product term.
        if (k == NUM_SLICES - 1) begin : g_last
            always_comb ep_mask[k] = 1'b1 | ep_q[k];
        end else begin : g_mid
            always_comb ep_mask[k] = ep_q[k];
        end

        pmatch_slice #(
            .NUM_INPUTS (NUM_INPUTS)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_sync),
            .prv      (pin_prev),
            .src      (src_q[k]),
            .mode     (mode_q[k]),
            .clr      (clr_k),
            .term     (term_vec[k]),
            .sticky_q (sticky_vec[k])
        );
    end

    pmatch_chain #(
        .NUM_SLICES (NUM_SLICES)
    ) u_chain (
        .term    (term_vec),
        .ep_mask (ep_mask),
        .prod    (prod)
    );

    // Purpose: register match vector, combined event and clear snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            event_q <= 1'b0;
            snap_q  <= '0;
        end else begin
            match_q <= prod;
            event_q <= event_enable & pm_enable & (|prod);
            if (clear_sticky) begin
                snap_q <= prod;
            end
        end
    end

    // Purpose: drive outputs; interrupt lines pick matcher or plain path.
    always_comb begin
        match_status    = match_q;
        event_out       = event_q;
        detect_snapshot = snap_q;
        irq_out         = pm_enable ? match_q : plain_irq;
    end
endmodule

// File: rtl/pmatch_engine_checker.sv
// Module: temporal properties of pmatch_engine, attached by bind.
// Assumes single-cycle strobes on cfg_we and clear_sticky.
module pmatch_engine_checker #(
    parameter int NUM_SLICES = 8,
    localparam int IDX_W = $clog2(NUM_SLICES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SLICES-1:0] match_status,
    input logic                  event_out,
    input logic [NUM_SLICES-1:0] detect_snapshot,
    input logic                  event_enable,
    input logic                  pm_enable,
    input logic                  clear_sticky,
    input logic                  cfg_we,
    input logic [IDX_W-1:0]      cfg_sel,
    input logic [NUM_SLICES-1:0] ep_mask,
    input logic [NUM_SLICES-1:0] sticky_vec
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (match_status == '0 && !event_out && detect_snapshot == '0));

    assert_nonend_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((match_status & ~$past(ep_mask)) == '0));

    assert_event_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        event_out |-> $past(event_enable && pm_enable));

    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_sticky) |-> $stable(detect_snapshot));

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_hold
        assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_vec[k] && !clear_sticky && !(cfg_we && cfg_sel == IDX_W'(k)))
            |=> sticky_vec[k]);
    end
endmodule

bind pmatch_engine pmatch_engine_checker #(
    .NUM_SLICES (NUM_SLICES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .match_status    (match_status),
    .event_out       (event_out),
    .detect_snapshot (detect_snapshot),
    .event_enable    (event_enable),
    .pm_enable       (pm_enable),
    .clear_sticky    (clear_sticky),
    .cfg_we          (cfg_we),
    .cfg_sel         (cfg_sel),
    .ep_mask         (ep_mask),
    .sticky_vec      (sticky_vec)
);

// File: tb/pmatch_engine_bench.sv
`timescale 1ns/100ps
module pmatch_engine_bench;
    localparam int NS = 8;
    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] pin_in = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [2:0]    cfg_src = '0;
    logic [2:0]    cfg_mode = '0;
    logic          cfg_endpoint = 1'b0;
    logic          pm_enable = 1'b0;
    logic          event_enable = 1'b0;
    logic          clear_sticky = 1'b0;
    logic [NS-1:0] plain_irq = '0;
    logic [NS-1:0] match_status;
    logic [NS-1:0] irq_out;
    logic          event_out;
    logic [NS-1:0] detect_snapshot;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    pmatch_engine u_pmatch_engine (
        .clk (clk), .rst_n (rst_n), .pin_in (pin_in),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_src (cfg_src),
        .cfg_mode (cfg_mode), .cfg_endpoint (cfg_endpoint),
        .pm_enable (pm_enable), .event_enable (event_enable),
        .clear_sticky (clear_sticky), .plain_irq (plain_irq),
        .match_status (match_status), .irq_out (irq_out),
        .event_out (event_out), .detect_snapshot (detect_snapshot)
    );

    always #2.5 clk = ~clk;

    // Reference model state (behavioural)
    int m_src [NS];
    int m_mode [NS];
    bit m_ep [NS];
    bit m_st [NS];
    bit m_s1 [NI];
    bit m_s2 [NI];
    bit m_prev [NI];
    logic [NS-1:0] exp_match = '0;
    logic [NS-1:0] exp_snap = '0;
    logic          exp_event = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                m_src[k] = 0; m_mode[k] = 6; m_ep[k] = 0; m_st[k] = 0;
            end
            for (int i = 0; i < NI; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
            end
            exp_match = '0; exp_snap = '0; exp_event = 1'b0;
        end else begin
            bit tv [NS];
            bit ev [NS];
            logic [NS-1:0] mc;
            bit run;
            for (int k = 0; k < NS; k++) begin
                bit nw, od, r, f;
                nw = m_s2[m_src[k]];
                od = m_prev[m_src[k]];
                r = nw && !od;
                f = !nw && od;
                ev[k] = (m_mode[k] == 1 && r) || (m_mode[k] == 2 && f) ||
                        (m_mode[k] == 3 && (r || f));
                case (m_mode[k])
                    0: tv[k] = 1;
                    1, 2, 3: tv[k] = m_st[k] || ev[k];
                    4: tv[k] = nw;
                    5: tv[k] = !nw;
                    6: tv[k] = 0;
                    default: tv[k] = r || f;
                endcase
            end
            run = 1;
            for (int k = 0; k < NS; k++) begin
                run = run && tv[k];
                if (m_ep[k] || k == NS - 1) begin
                    mc[k] = run; run = 1;
                end else begin
                    mc[k] = 0;
                end
            end
            exp_match = mc;
            exp_event = event_enable && pm_enable && (mc != 0);
            if (clear_sticky) exp_snap = mc;
            for (int k = 0; k < NS; k++) begin
                if (clear_sticky || (cfg_we && int'(cfg_sel) == k)) m_st[k] = 0;
                else if (ev[k]) m_st[k] = 1;
            end
            if (cfg_we) begin
                m_src[cfg_sel] = int'(cfg_src);
                m_mode[cfg_sel] = int'(cfg_mode);
                m_ep[cfg_sel] = cfg_endpoint;
            end
            for (int i = 0; i < NI; i++) begin
                m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin_in[i];
            end
        end
    end

    task automatic check_vec(string what, logic [NS-1:0] got, logic [NS-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h expected %h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    // Compare on every falling edge once reset is applied
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check_vec("match_status", match_status, exp_match);
            check_vec("irq_out", irq_out, pm_enable ? exp_match : plain_irq);
            check_vec("event_out", {{(NS-1){1'b0}}, event_out}, {{(NS-1){1'b0}}, exp_event});
            check_vec("detect_snapshot", detect_snapshot, exp_snap);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic cfg(int s, int src, int mode, bit ep);
        cfg_we = 1; cfg_sel = 3'(s); cfg_src = 3'(src); cfg_mode = 3'(mode); cfg_endpoint = ep;
        tick(1);
        cfg_we = 0;
    endtask

    task automatic clr_pulse();
        clear_sticky = 1; tick(1); clear_sticky = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
    end

    initial begin
        cmp_on = 1;
        tick(4);
        cur_req = "R1";
        rst_n = 1;
        tick(3);
        pm_enable = 1;

        // R3 / R11: high level on pin 3, slice 0 endpoint
        cur_req = "R3";
        cfg(0, 3, 4, 1);
        pin_in[3] = 1; tick(1);
        cur_req = "R11"; tick(4);
        cur_req = "R3";
        pin_in[3] = 0; tick(5);
        cfg(0, 3, 5, 1); tick(4);
        cfg(0, 3, 0, 1); tick(3);
        cfg(0, 3, 6, 1); tick(3);

        // R2: source selection, other pins ignored
        cur_req = "R2";
        cfg(0, 5, 4, 1);
        pin_in = 8'hDF; tick(5);
        pin_in = 8'h20; tick(5);
        pin_in = 8'h00; tick(4);

        // R5: single-cycle edge
        cur_req = "R5";
        cfg(0, 1, 7, 1);
        pin_in[1] = 1; tick(6);
        pin_in[1] = 0; tick(6);

        // R4: sticky codes held until clear / rewrite
        cur_req = "R4";
        cfg(0, 2, 1, 1);
        cfg(1, 2, 2, 1);
        cfg(2, 2, 3, 1);
        pin_in[2] = 1; tick(6);
        pin_in[2] = 0; tick(6);
        cur_req = "R10";
        clr_pulse(); tick(4);
        cur_req = "R4";
        pin_in[2] = 1; tick(6);
        cfg(2, 2, 3, 1); tick(4);
        pin_in[2] = 0; tick(6);
        clr_pulse(); tick(3);

        // R6: three product terms
        cur_req = "R6";
        cfg(0, 0, 4, 0); cfg(1, 1, 4, 0); cfg(2, 0, 0, 1);
        cfg(3, 2, 4, 0); cfg(4, 3, 5, 0); cfg(5, 4, 4, 1);
        cfg(6, 6, 4, 0); cfg(7, 7, 4, 0);
        for (int v = 0; v < 32; v++) begin
            pin_in = 8'(v * 37 + 5); tick(4);
        end

        // R7: last slice closes its term even with flag clear
        cur_req = "R7";
        cfg(7, 7, 4, 0);
        cfg(5, 4, 0, 0); cfg(6, 6, 0, 0);
        pin_in = 8'h80; tick(5);
        pin_in = 8'h00; tick(5);

        // R8: interrupt line routing
        cur_req = "R8";
        for (int v = 0; v < 8; v++) begin
            pm_enable = v[0]; plain_irq = 8'(v * 29 + 3); pin_in = 8'(v * 53); tick(4);
        end
        pm_enable = 1;

        // R9: event output gating
        cur_req = "R9";
        cfg(2, 0, 0, 1);
        event_enable = 1; tick(4);
        pm_enable = 0; tick(3);
        pm_enable = 1; event_enable = 0; tick(3);
        event_enable = 1; tick(3);

        // R10: snapshot at clear
        cur_req = "R10";
        clr_pulse(); tick(3);
        pin_in = 8'hFF; tick(4);
        clr_pulse(); tick(3);

        // Mixed random phase
        cur_req = "R6";
        for (int n = 0; n < 1500; n++) begin
            pin_in = 8'($urandom);
            if (($urandom % 4) == 0) begin
                cfg_we = 1; cfg_sel = 3'($urandom); cfg_src = 3'($urandom);
                cfg_mode = 3'($urandom); cfg_endpoint = 1'($urandom);
            end
            clear_sticky = (($urandom % 16) == 0);
            event_enable = (($urandom % 8) != 0);
            pm_enable = (($urandom % 8) != 0);
            plain_irq = 8'($urandom);
            tick(1);
            cfg_we = 0; clear_sticky = 0;
        end
        tick(4);

        // R1: return to reset state
        cur_req = "R1";
        rst_n = 0; tick(2);
        rst_n = 1; tick(3);

        done = 1;
        finish_run();
    end
endmodule